// File: doc/BRIEF.md
# RTC Indexed Host Access Port

This block sits between a host processor and a real-time clock. The host reaches the clock's 128-byte register space through two ports: an index port and a data port. Three control lines from a parallel port decide what happens in each cycle. One line gives the direction, one strobes the index port and one strobes the data port. An 8-bit bus carries the write data. The host first writes an index, then reads or writes the byte that the index selects.

The block holds the index latch and sorts the index into four regions:
- the counting and control registers, whose contents belong to an external timekeeping core;
- a read-only status byte;
- general-purpose storage that keeps its contents across reset;
- a reserved upper half.

Counting-register writes go to the timekeeping core as a one-cycle strobe with an address and a byte. Counting-register contents come back as a flat vector. Reading the interrupt-flag register sends a clear pulse to the flag logic in the same cycle that the captured value appears on the output.

Top module: `rtc_host_port`

## Requirements
- R1: While reset is asserted and straight after it, `dout` is 00h, `flag_clr` and `ext_wr_stb` are 0, and the index latch is 00h. A data read before any index write therefore returns the byte at address 00h.
- R2: When `ctl` = 3'b010 (bit 0 = 0 is write, bit 1 = 1 is the index strobe, bit 2 = 0), `din` is loaded into the index latch. Later data accesses use that index.
- R3: When `ctl` = 3'b101 (read data) and the index is 00h–0Ch, the byte `ext_rd_data[8*i +: 8]` appears on `dout` in the next cycle. `dout` keeps its value until the next data read.
- R4: When `ctl` = 3'b100 (write data) and the index is 00h–0Ch, the next cycle has `ext_wr_stb` = 1 for exactly one cycle, with `ext_wr_addr` equal to the index and `ext_wr_data` equal to the `din` of that write.
- R5: Addresses 0Eh–7Fh are local storage. A data write stores `din`, and a later data read returns the stored byte. Reset does not clear this storage.
- R6: A read of 0Dh returns `{status_ok, 7'b0}`. A write to 0Dh raises no `ext_wr_stb` and changes nothing.
- R7: A data read of 0Ch gives a one-cycle `flag_clr` pulse in the cycle that `dout` first shows the 0Ch byte. No other access raises `flag_clr`.
- R8: An index with bit 7 set (80h–FFh) is reserved. A read returns 00h. A write raises no strobe and does not change the storage at the address given by the low 7 bits.
- R9: When `ctl` bits 1 and 2 are both 1, only the index access happens. There is no data write, no strobe, no `flag_clr`, and `dout` holds.
- R10: An index read (`ctl` = 3'b011) has no effect: `dout` holds and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl | input | 3 | bit0 direction (1 = read), bit1 index strobe, bit2 data strobe |
| din | input | 8 | Host write data |
| dout | output | 8 | Captured read data |
| ext_rd_data | input | 104 | Contents of registers 00h–0Ch, byte i at bits 8i+7:8i |
| status_ok | input | 1 | Valid-RAM-and-time flag, shown as bit 7 of 0Dh |
| ext_wr_stb | output | 1 | One-cycle write strobe to the timekeeping core |
| ext_wr_addr | output | 4 | Register number of the strobed write |
| ext_wr_data | output | 8 | Byte of the strobed write |
| flag_clr | output | 1 | Clear pulse to the interrupt-flag logic |

## Verification
The assertions assume that every cycle in which `ctl` names an access is one access. They also assume that `ctl` and `din` are steady around the rising edge, and that `ext_rd_data` and `status_ok` do not change between a read strobe and the cycle after it. The stimulus drives every input on the falling edge and holds it for one full cycle. It returns `ctl` to idle between accesses. It changes `status_ok` and `ext_rd_data` only while the port is idle.

// File: rtl/rtc_port_pkg.sv
`timescale 1ns/1ps
package rtc_port_pkg;
  // decoded address region of the current index
  typedef enum logic [1:0] {
    RG_CLOCK  = 2'd0,
    RG_STATUS = 2'd1,
    RG_RAM    = 2'd2,
    RG_RSVD   = 2'd3
  } region_e;

  // one access kind per cycle, at most one bit set
  typedef struct packed {
    logic idx_wr;
    logic dat_rd;
    logic dat_wr;
  } access_t;

  localparam int unsigned CTL_DIR_BIT = 0;
  localparam int unsigned CTL_IDX_BIT = 1;
  localparam int unsigned CTL_DAT_BIT = 2;
endpackage

// File: rtl/rtc_strobe_decode.sv
`timescale 1ns/1ps
module rtc_strobe_decode
  import rtc_port_pkg::*;
(
  input  logic [2:0] ctl,
  output access_t    acc
);
  logic rd;
  logic idx_s;
  logic dat_s;

  always_comb begin
    rd    = ctl[CTL_DIR_BIT];
    idx_s = ctl[CTL_IDX_BIT];
    dat_s = ctl[CTL_DAT_BIT];
    // index strobe takes priority; an index read does nothing
    acc.idx_wr = idx_s & ~rd;
    acc.dat_rd = dat_s & ~idx_s & rd;
    acc.dat_wr = dat_s & ~idx_s & ~rd;
  end
endmodule

// File: rtl/rtc_index_latch.sv
`timescale 1ns/1ps
module rtc_index_latch #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] value,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_d = idx;
    if (load) idx_d = value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_d;
  end
endmodule

// File: rtl/rtc_region_decode.sv
`timescale 1ns/1ps
module rtc_region_decode
  import rtc_port_pkg::*;
#(
  parameter int unsigned SEL_W       = 7,
  parameter int unsigned CLK_REGS    = 13,
  parameter int unsigned STATUS_ADDR = 13,
  parameter int unsigned CSEL_W      = 4
) (
  input  logic [SEL_W:0]    idx,
  output region_e           region,
  output logic [CSEL_W-1:0] clk_sel,
  output logic [SEL_W-1:0]  ram_sel
);
  localparam logic [SEL_W-1:0] LAST_CLK = SEL_W'(CLK_REGS - 1);
  localparam logic [SEL_W-1:0] STAT_A   = SEL_W'(STATUS_ADDR);
  localparam logic [SEL_W-1:0] RAM_BASE = SEL_W'(STATUS_ADDR + 1);

  logic [SEL_W-1:0] low;

  always_comb begin
    low     = idx[SEL_W-1:0];
    clk_sel = low[CSEL_W-1:0];
    ram_sel = low - RAM_BASE;
    if (idx[SEL_W])            region = RG_RSVD;
    else if (low <= LAST_CLK)  region = RG_CLOCK;
    else if (low == STAT_A)    region = RG_STATUS;
    else                       region = RG_RAM;
  end
endmodule

// File: rtl/rtc_nvram.sv
`timescale 1ns/1ps
module rtc_nvram #(
  parameter int unsigned DEPTH  = 114,
  parameter int unsigned AW     = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  // contents survive reset, so the array has no reset branch
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  always_comb begin
    if (int'(raddr) < DEPTH) rdata = mem[raddr];
    else                     rdata = '0;
  end
endmodule

// File: rtl/rtc_host_port.sv
`timescale 1ns/1ps
module rtc_host_port
  import rtc_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SPACE       = 128,
  parameter int unsigned CLK_REGS    = 13,
  parameter int unsigned STATUS_ADDR = 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [2:0]                   ctl,
  input  logic [DATA_W-1:0]            din,
  output logic [DATA_W-1:0]            dout,
  input  logic [CLK_REGS*DATA_W-1:0]   ext_rd_data,
  input  logic                         status_ok,
  output logic                         ext_wr_stb,
  output logic [$clog2(CLK_REGS)-1:0]  ext_wr_addr,
  output logic [DATA_W-1:0]            ext_wr_data,
  output logic                         flag_clr
);
  localparam int unsigned SEL_W     = $clog2(SPACE);
  localparam int unsigned IDX_W     = SEL_W + 1;
  localparam int unsigned CSEL_W    = $clog2(CLK_REGS);
  localparam int unsigned RAM_DEPTH = SPACE - STATUS_ADDR - 1;
  localparam logic [CSEL_W-1:0] FLAG_SEL = CSEL_W'(CLK_REGS - 1);

  access_t           acc;
  logic [IDX_W-1:0]  idx_q;
  region_e           region;
  logic [CSEL_W-1:0] clk_sel;
  logic [SEL_W-1:0]  ram_sel;
  logic [DATA_W-1:0] ram_rdata;
  logic              ram_we;

  logic [DATA_W-1:0] rd_d, rd_q;
  logic              clr_d, clr_q;
  logic              stb_d, stb_q;
  logic [CSEL_W-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q;

  rtc_strobe_decode u_strobe (
    .ctl (ctl),
    .acc (acc)
  );

  rtc_index_latch #(.IDX_W(IDX_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (acc.idx_wr),
    .value (din[IDX_W-1:0]),
    .idx   (idx_q)
  );

  rtc_region_decode #(
    .SEL_W(SEL_W), .CLK_REGS(CLK_REGS),
    .STATUS_ADDR(STATUS_ADDR), .CSEL_W(CSEL_W)
  ) u_region (
    .idx     (idx_q),
    .region  (region),
    .clk_sel (clk_sel),
    .ram_sel (ram_sel)
  );

  assign ram_we = acc.dat_wr && (region == RG_RAM);

  rtc_nvram #(.DEPTH(RAM_DEPTH), .AW(SEL_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_sel),
    .wdata (din),
    .raddr (ram_sel),
    .rdata (ram_rdata)
  );

  // next state of the read path
  always_comb begin
    rd_d  = rd_q;
    clr_d = 1'b0;
    if (acc.dat_rd) begin
      unique case (region)
        RG_CLOCK:  rd_d = ext_rd_data[int'(clk_sel)*DATA_W +: DATA_W];
        RG_STATUS: rd_d = {status_ok, {(DATA_W-1){1'b0}}};
        RG_RAM:    rd_d = ram_rdata;
        default:   rd_d = '0;
      endcase
      clr_d = (region == RG_CLOCK) && (clk_sel == FLAG_SEL);
    end
  end

  // next state of the write path toward the timekeeping core
  always_comb begin
    stb_d = acc.dat_wr && (region == RG_CLOCK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      clr_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      clr_q <= clr_d;
      stb_q <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (stb_d) begin
      waddr_q <= clk_sel;
      wdata_q <= din;
    end
  end

  assign dout        = rd_q;
  assign flag_clr    = clr_q;
  assign ext_wr_stb  = stb_q;
  assign ext_wr_addr = waddr_q;
  assign ext_wr_data = wdata_q;
endmodule

// File: rtl/rtc_host_port_chk.sv
`timescale 1ns/1ps
module rtc_host_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] ctl,
  input logic [7:0] din,
  input logic [7:0] dout,
  input logic       ext_wr_stb,
  input logic [7:0] ext_wr_data,
  input logic       flag_clr,
  input logic [7:0] idx
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_out_chk: assert (dout == 8'h00 && !flag_clr && !ext_wr_stb);
  end

  // R4
  wr_strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_stb |-> ($past(ctl) == 3'b100 && ext_wr_data == $past(din)));

  // R7
  flag_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |-> ($past(ctl) == 3'b101 && $past(idx) == 8'h0C));

  // R9
  idx_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[1] && ctl[2]) |=> (!ext_wr_stb && !flag_clr && $stable(dout)));

  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl != 3'b101) |=> $stable(dout));

  // R8
  rsvd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx[7] && ctl == 3'b100) |=> !ext_wr_stb);

  // R8
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx[7] && ctl == 3'b101) |=> (dout == 8'h00));
endmodule

bind rtc_host_port rtc_host_port_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl         (ctl),
  .din         (din),
  .dout        (dout),
  .ext_wr_stb  (ext_wr_stb),
  .ext_wr_data (ext_wr_data),
  .flag_clr    (flag_clr),
  .idx         (idx_q)
);

// File: tb/rtc_host_port_tb.sv
`timescale 1ns/1ps
module rtc_host_port_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   ctl;
  logic [7:0]   din;
  logic [7:0]   dout;
  logic [103:0] ext_rd_data;
  logic         status_ok;
  logic         ext_wr_stb;
  logic [3:0]   ext_wr_addr;
  logic [7:0]   ext_wr_data;
  logic         flag_clr;

  int errors = 0;
  int checks = 0;
  logic [7:0] ram_model [128];

  always #2.5 clk = ~clk;

  rtc_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .din(din), .dout(dout),
    .ext_rd_data(ext_rd_data), .status_ok(status_ok),
    .ext_wr_stb(ext_wr_stb), .ext_wr_addr(ext_wr_addr),
    .ext_wr_data(ext_wr_data), .flag_clr(flag_clr)
  );

  function automatic logic [7:0] ext_byte(int a);
    return 8'((a * 29 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one access for a cycle; return at the next falling edge with results visible
  task automatic acc(input logic [2:0] c, input logic [7:0] d);
    @(negedge clk);
    ctl = c;
    din = d;
    @(negedge clk);
    ctl = 3'b000;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    rst_n = 1'b0;
    ctl = 3'b000;
    din = 8'h00;
    status_ok = 1'b1;
    for (int i = 0; i < 13; i++) ext_rd_data[i*8 +: 8] = ext_byte(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dout == 8'h00 && !flag_clr && !ext_wr_stb, "R1", dout, 0);
    rst_n = 1'b1;
    @(negedge clk);
    acc(3'b101, 8'h00);
    chk(dout == ext_byte(0), "R1 index zero", dout, ext_byte(0));

    // R2 R3 R4 R7 counting and control registers
    for (int a = 0; a < 13; a++) begin
      acc(3'b010, 8'(a));
      acc(3'b100, 8'(a ^ 8'hA5));
      chk(ext_wr_stb == 1'b1, "R4 strobe", ext_wr_stb, 1);
      chk(ext_wr_addr == 4'(a), "R4 addr", ext_wr_addr, a);
      chk(ext_wr_data == 8'(a ^ 8'hA5), "R4 data", ext_wr_data, a ^ 8'hA5);
      @(negedge clk);
      chk(ext_wr_stb == 1'b0, "R4 one cycle", ext_wr_stb, 0);
      acc(3'b101, 8'h00);
      chk(dout == ext_byte(a), "R2 R3 read", dout, ext_byte(a));
      chk(flag_clr == (a == 12), "R7 pulse", flag_clr, a == 12);
      @(negedge clk);
      chk(flag_clr == 1'b0 && dout == ext_byte(a), "R7 R3 hold", dout, ext_byte(a));
    end

    // R5 storage sweep
    for (int a = 14; a < 128; a++) begin
      ram_model[a] = 8'((a * 7 + 3) & 255);
      acc(3'b010, 8'(a));
      acc(3'b100, ram_model[a]);
      chk(ext_wr_stb == 1'b0, "R5 no strobe", ext_wr_stb, 0);
    end
    for (int a = 14; a < 128; a++) begin
      acc(3'b010, 8'(a));
      acc(3'b101, 8'h00);
      chk(dout == ram_model[a], "R5 readback", dout, ram_model[a]);
      chk(flag_clr == 1'b0, "R7 none", flag_clr, 0);
    end

    // R6 status byte
    acc(3'b010, 8'h0D);
    acc(3'b100, 8'h00);
    chk(ext_wr_stb == 1'b0, "R6 write ignored", ext_wr_stb, 0);
    acc(3'b101, 8'h00);
    chk(dout == 8'h80, "R6 ok", dout, 8'h80);
    status_ok = 1'b0;
    acc(3'b101, 8'h00);
    chk(dout == 8'h00, "R6 low", dout, 0);
    status_ok = 1'b1;

    // R8 reserved half
    for (int a = 128; a < 256; a++) begin
      acc(3'b010, 8'(a));
      acc(3'b100, 8'hFF);
      chk(ext_wr_stb == 1'b0, "R8 no strobe", ext_wr_stb, 0);
      acc(3'b101, 8'h00);
      chk(dout == 8'h00, "R8 read zero", dout, 0);
    end
    for (int a = 14; a < 128; a++) begin
      acc(3'b010, 8'(a));
      acc(3'b101, 8'h00);
      chk(dout == ram_model[a], "R8 alias kept", dout, ram_model[a]);
    end

    // R9 both strobes: index wins
    acc(3'b010, 8'd14);
    acc(3'b110, 8'd20);
    chk(ext_wr_stb == 1'b0, "R9 no write", ext_wr_stb, 0);
    acc(3'b101, 8'h00);
    chk(dout == ram_model[20], "R9 new index", dout, ram_model[20]);
    acc(3'b010, 8'd14);
    acc(3'b101, 8'h00);
    chk(dout == ram_model[14], "R9 data kept", dout, ram_model[14]);
    acc(3'b010, 8'h0C);
    prev = dout;
    acc(3'b111, 8'h0C);
    chk(flag_clr == 1'b0 && dout == prev, "R9 no read", dout, prev);

    // R10 index read does nothing
    acc(3'b011, 8'h05);
    chk(flag_clr == 1'b0 && dout == prev, "R10 hold", dout, prev);
    acc(3'b101, 8'h00);
    chk(dout == ext_byte(12) && flag_clr, "R10 index kept", dout, ext_byte(12));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule